// File: doc/BRIEF.md
# Slave-FIFO Bus Activity Statistics Recorder

This block sits beside a slave-FIFO bus controller and watches the four active-low control strobes and the two-bit buffer address the controller drives. It counts how often the controller asserted each strobe. It keeps two separate circular histories of buffer addresses: one for the read side, where data is taken from the host-facing device, and one for the write side, where data is handed back. It also mirrors two values from the controller: the buffer address it intends to use next, and the word count of its local loopback FIFO. With these, a host that aborted a stalled transfer can read back where the controller stopped.

A host reads every value through a plain register port. It presents an index on `reg_addr` and gets the selected word on `reg_data` one clock later. The `clr` input is pulsed at the start of each test iteration. It empties all counters and both histories.

The read history records an address once per buffer. A buffer opens at the first read-strobe falling edge after a clear, or after the address bus has changed. The write history follows the same rule, and a falling edge of the packet-end strobe also closes the open write buffer.

Top module: `bus_stats_recorder`

## Requirements
- R1: Indices 0, 1, 2 and 3 return the counts of the output-enable, read, write and packet-end strobes. Each count goes up by one on every high-to-low transition of its strobe, and not on every cycle the strobe stays low.
- R2: A count that has reached its all-ones value (2^CNT_W - 1) keeps that value on further transitions.
- R3: A cycle with `clr` high sets all four counts to zero and empties both histories. No strobe transition in that cycle is counted or recorded.
- R4: The read history gains one entry when a read-strobe falling edge occurs while no read buffer is open. A read buffer is closed after reset or clear, and in any cycle where `fifo_addr` differs from its value in the previous cycle. Each entry is {1'b1, fifo_addr}, so bit ADDR_W marks it valid.
- R5: The write history follows the R4 rule for the write strobe. In addition, a packet-end falling edge closes the open write buffer from the next cycle on.
- R6: Each history holds the last HIST_DEPTH entries. Indices HIST_DEPTH to 2*HIST_DEPTH-1 read the read history and 2*HIST_DEPTH to 3*HIST_DEPTH-1 read the write history. Offset 0 is the oldest entry kept, and offsets beyond the filled part read as zero.
- R7: Index 4 returns `next_addr` and index 5 returns `fifo_words`, both zero-extended.
- R8: `reg_data` is registered. It shows the value selected by `reg_addr` as it was at the previous rising clock edge. Indices 6 to HIST_DEPTH-1 and 3*HIST_DEPTH and above read as zero.
- R9: After reset, all counts and history entries read as zero and `reg_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of counts and histories |
| oe_n | input | 1 | Output-enable strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| pkt_n | input | 1 | Packet-end strobe, active low |
| fifo_addr | input | ADDR_W | Buffer address driven by the controller |
| next_addr | input | ADDR_W | Address the controller intends to use next |
| fifo_words | input | WORDS_W | Current word count of the loopback FIFO |
| reg_addr | input | REG_AW | Register index |
| reg_data | output | DATA_W | Registered read data |

## Verification
A wrong edge detector shows up one read later as a count that is too large after a long strobe assertion, or as a count that never moves. A wrong buffer-open flag shows up as a history entry that is missing or duplicated. The same happens when the flag ignores an address change or a packet-end. A wrong write pointer or fill count turns the oldest-first order of the history indices around. All of these reach `reg_data` one cycle after the affected index is presented. Because the bench sweeps every index continuously, any divergence appears within one sweep of the register space.

// File: rtl/bus_stats_pkg.sv
package bus_stats_pkg;

   localparam int NUM_STROBES = 4;
   localparam int SCALAR_REGS = 6;

   // strobe lanes, also the register index of each count
   typedef enum logic [1:0] {
      LANE_OE  = 2'd0,
      LANE_RD  = 2'd1,
      LANE_WR  = 2'd2,
      LANE_PKT = 2'd3
   } strobe_lane_e;

   typedef enum logic [2:0] {
      SEL_CNT_OE  = 3'd0,
      SEL_CNT_RD  = 3'd1,
      SEL_CNT_WR  = 3'd2,
      SEL_CNT_PKT = 3'd3,
      SEL_NEXT    = 3'd4,
      SEL_WORDS   = 3'd5
   } scalar_sel_e;

   typedef enum logic [1:0] {
      REGION_SCALAR,
      REGION_OUT,
      REGION_IN,
      REGION_NONE
   } region_e;

endpackage

// File: rtl/bus_stats_edge_counter.sv
module bus_stats_edge_counter #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe_n,
   output logic             fall,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic strobe_q;
   logic at_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b1;
      else        strobe_q <= strobe_n;
   end

   assign fall = strobe_q & ~strobe_n;

   generate
      if (SATURATE) begin : g_sat
         assign at_max = (count == CNT_MAX);
      end else begin : g_wrap
         assign at_max = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clr)              count <= '0;
      else if (fall && !at_max)  count <= count + 1'b1;
   end

endmodule

// File: rtl/bus_stats_addr_history.sv
module bus_stats_addr_history #(
   parameter int  ADDR_W  = 2,
   parameter int  DEPTH   = 32,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int ENTRY_W = ADDR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               strobe_fall,
   input  logic               close_evt,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [PTR_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic [PTR_W-1:0]   wptr
);

   localparam logic [PTR_W:0] FILL_FULL = (PTR_W+1)'(DEPTH);

   logic [ADDR_W-1:0]  addr_q;
   logic               open_q;
   logic               open_eff;
   logic               push;
   logic [PTR_W:0]     fill_q;
   logic [PTR_W-1:0]   wptr_q;
   logic [PTR_W-1:0]   phys_idx;
   logic [ENTRY_W-1:0] mem [DEPTH];

   // a changed address ends the buffer that was open
   assign open_eff = open_q & (bus_addr == addr_q);
   assign push     = strobe_fall & ~open_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= bus_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   open_q <= 1'b0;
      else if (clr) open_q <= 1'b0;
      else          open_q <= (open_eff | strobe_fall) & ~close_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         fill_q <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         fill_q <= '0;
      end else if (push) begin
         wptr_q <= wptr_q + 1'b1;
         if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  mem[g] <= '0;
            else if (clr)                                mem[g] <= '0;
            else if (push && (wptr_q == PTR_W'(g)))      mem[g] <= {1'b1, bus_addr};
         end
      end
   endgenerate

   // oldest-first view: once full, the oldest entry sits at the write pointer
   assign phys_idx = (fill_q == FILL_FULL) ? (wptr_q + rd_idx) : rd_idx;
   assign rd_entry = mem[phys_idx];
   assign wptr     = wptr_q;

endmodule

// File: rtl/bus_stats_recorder.sv
module bus_stats_recorder
   import bus_stats_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 2,
   parameter int WORDS_W    = 13,
   parameter int HIST_DEPTH = 32,
   parameter int REG_AW     = 7,
   parameter bit SATURATE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               oe_n,
   input  logic               rd_n,
   input  logic               wr_n,
   input  logic               pkt_n,
   input  logic [ADDR_W-1:0]  fifo_addr,
   input  logic [ADDR_W-1:0]  next_addr,
   input  logic [WORDS_W-1:0] fifo_words,
   input  logic [REG_AW-1:0]  reg_addr,
   output logic [DATA_W-1:0]  reg_data
);

   localparam int PTR_W   = $clog2(HIST_DEPTH);
   localparam int ENTRY_W = ADDR_W + 1;
   localparam logic [REG_AW-1:0] SCALAR_END = REG_AW'(SCALAR_REGS);
   localparam logic [REG_AW-1:0] OUT_BASE   = REG_AW'(HIST_DEPTH);
   localparam logic [REG_AW-1:0] IN_BASE    = REG_AW'(2 * HIST_DEPTH);
   localparam logic [REG_AW-1:0] MAP_END    = REG_AW'(3 * HIST_DEPTH);

   // elaboration-time parameter checks
   generate
      if (((HIST_DEPTH & (HIST_DEPTH - 1)) != 0) || (HIST_DEPTH < 8)) begin : g_bad_depth
         $error("HIST_DEPTH must be a power of two of at least 8");
      end
      if ((3 * HIST_DEPTH) >= (1 << REG_AW)) begin : g_bad_aw
         $error("REG_AW too narrow for the register map");
      end
      if ((CNT_W > DATA_W) || (WORDS_W > DATA_W) || (ENTRY_W > DATA_W)) begin : g_bad_w
         $error("a field is wider than DATA_W");
      end
   endgenerate

   logic [NUM_STROBES-1:0]            strobe_n_vec;
   logic [NUM_STROBES-1:0]            falls;
   logic [NUM_STROBES-1:0][CNT_W-1:0] cnt_bank;
   logic [ENTRY_W-1:0]                out_entry;
   logic [ENTRY_W-1:0]                in_entry;
   logic [PTR_W-1:0]                  out_wptr;
   logic [PTR_W-1:0]                  in_wptr;
   logic [PTR_W-1:0]                  hist_idx;
   region_e                           region;
   logic [DATA_W-1:0]                 data_nx;

   assign strobe_n_vec = {pkt_n, wr_n, rd_n, oe_n};

   generate
      for (genvar s = 0; s < NUM_STROBES; s++) begin : g_lane
         bus_stats_edge_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .strobe_n (strobe_n_vec[s]),
            .fall     (falls[s]),
            .count    (cnt_bank[s])
         );
      end
   endgenerate

   assign hist_idx = reg_addr[PTR_W-1:0];

   bus_stats_addr_history #(
      .ADDR_W (ADDR_W),
      .DEPTH  (HIST_DEPTH)
   ) u_out_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .strobe_fall (falls[LANE_RD]),
      .close_evt   (1'b0),
      .bus_addr    (fifo_addr),
      .rd_idx      (hist_idx),
      .rd_entry    (out_entry),
      .wptr        (out_wptr)
   );

   bus_stats_addr_history #(
      .ADDR_W (ADDR_W),
      .DEPTH  (HIST_DEPTH)
   ) u_in_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .strobe_fall (falls[LANE_WR]),
      .close_evt   (falls[LANE_PKT]),
      .bus_addr    (fifo_addr),
      .rd_idx      (hist_idx),
      .rd_entry    (in_entry),
      .wptr        (in_wptr)
   );

   always_comb begin
      if (reg_addr < OUT_BASE)     region = REGION_SCALAR;
      else if (reg_addr < IN_BASE) region = REGION_OUT;
      else if (reg_addr < MAP_END) region = REGION_IN;
      else                         region = REGION_NONE;
   end

   always_comb begin
      data_nx = '0;
      unique case (region)
         REGION_SCALAR: begin
            if (reg_addr < SCALAR_END) begin
               case (scalar_sel_e'(reg_addr[2:0]))
                  SEL_CNT_OE:  data_nx = DATA_W'(cnt_bank[LANE_OE]);
                  SEL_CNT_RD:  data_nx = DATA_W'(cnt_bank[LANE_RD]);
                  SEL_CNT_WR:  data_nx = DATA_W'(cnt_bank[LANE_WR]);
                  SEL_CNT_PKT: data_nx = DATA_W'(cnt_bank[LANE_PKT]);
                  SEL_NEXT:    data_nx = DATA_W'(next_addr);
                  SEL_WORDS:   data_nx = DATA_W'(fifo_words);
                  default:     data_nx = '0;
               endcase
            end
         end
         REGION_OUT:  data_nx = DATA_W'(out_entry);
         REGION_IN:   data_nx = DATA_W'(in_entry);
         REGION_NONE: data_nx = '0;
         default:     data_nx = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_data <= '0;
      else        reg_data <= data_nx;
   end

endmodule

// File: rtl/bus_stats_checker.sv
module bus_stats_checker #(
   parameter int CNT_W      = 32,
   parameter int DATA_W     = 32,
   parameter int HIST_DEPTH = 32,
   parameter int REG_AW     = 7,
   parameter int PTR_W      = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  clr,
   input logic                  rd_n,
   input logic [3:0][CNT_W-1:0] cnt_bank,
   input logic [PTR_W-1:0]      out_wptr,
   input logic [REG_AW-1:0]     reg_addr,
   input logic [DATA_W-1:0]     reg_data
);

   localparam logic [CNT_W-1:0]  CMAX     = '1;
   localparam logic [REG_AW-1:0] GAP_LO   = REG_AW'(6);
   localparam logic [REG_AW-1:0] GAP_HI   = REG_AW'(HIST_DEPTH);
   localparam logic [REG_AW-1:0] MAP_END  = REG_AW'(3 * HIST_DEPTH);

   logic rd_seen_q;
   logic rd_fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_seen_q <= 1'b1;
      else        rd_seen_q <= rd_n;
   end

   assign rd_fell = rd_seen_q & ~rd_n;

   // R1: read count holds when the read strobe did not fall
   assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !rd_fell) |=> $stable(cnt_bank[1]));

   // R1: read count steps by exactly one on a falling edge below the limit
   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && rd_fell && (cnt_bank[1] != CMAX)) |=> (cnt_bank[1] == $past(cnt_bank[1]) + 1'b1));

   // R2: a saturated count stays saturated
   assert_cnt_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (cnt_bank[0] == CMAX)) |=> (cnt_bank[0] == CMAX));

   // R3: clear empties every count
   assert_clear_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_bank == '0));

   // R4: the read history pointer moves only on a read-strobe falling edge
   assert_push_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !rd_fell) |=> $stable(out_wptr));

   // R8: unmapped indices read zero one cycle later
   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr >= MAP_END) || ((reg_addr >= GAP_LO) && (reg_addr < GAP_HI))) |=> (reg_data == '0));

endmodule

bind bus_stats_recorder bus_stats_checker #(
   .CNT_W      (CNT_W),
   .DATA_W     (DATA_W),
   .HIST_DEPTH (HIST_DEPTH),
   .REG_AW     (REG_AW),
   .PTR_W      (PTR_W)
) u_bus_stats_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .rd_n     (rd_n),
   .cnt_bank (cnt_bank),
   .out_wptr (out_wptr),
   .reg_addr (reg_addr),
   .reg_data (reg_data)
);

// File: tb/test_bus_stats_recorder.sv
module test_bus_stats_recorder;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int DATA_W     = 32;
   localparam int ADDR_W     = 2;
   localparam int WORDS_W    = 13;
   localparam int DEPTH      = 32;
   localparam int REG_AW     = 7;
   localparam int CMAX       = (1 << CNT_W) - 1;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic oe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, pkt_n = 1'b1;
   logic [ADDR_W-1:0]  fifo_addr = '0;
   logic [ADDR_W-1:0]  next_addr = '0;
   logic [WORDS_W-1:0] fifo_words = '0;
   logic [REG_AW-1:0]  reg_addr = '0;
   logic [DATA_W-1:0]  reg_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bus_stats_recorder #(
      .CNT_W      (CNT_W),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .WORDS_W    (WORDS_W),
      .HIST_DEPTH (DEPTH),
      .REG_AW     (REG_AW),
      .SATURATE   (1'b1)
   ) i_bus_stats_recorder (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .oe_n       (oe_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .pkt_n      (pkt_n),
      .fifo_addr  (fifo_addr),
      .next_addr  (next_addr),
      .fifo_words (fifo_words),
      .reg_addr   (reg_addr),
      .reg_data   (reg_data)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // behavioural reference state
   int  cnt [4];
   bit  prev [4];
   int  out_q [$];
   int  in_q [$];
   bit  rd_open, wr_open;
   int  addr_prev;
   int  cur_a;
   int  ra_seq;
   bit  cmp_en;
   logic [DATA_W-1:0] exp_data;
   string phase;

   function automatic string reg_tag(int x);
      if (x < 4)                   return "R1";
      if (x < 6)                   return "R7";
      if (x >= DEPTH && x < 2*DEPTH)   return "R4";
      if (x >= 2*DEPTH && x < 3*DEPTH) return "R5";
      return "R8";
   endfunction

   function automatic logic [DATA_W-1:0] model_read(int x);
      if (x < 4)  return DATA_W'(cnt[x]);
      if (x == 4) return DATA_W'(next_addr);
      if (x == 5) return DATA_W'(fifo_words);
      if (x >= DEPTH && x < 2*DEPTH)
         return (x - DEPTH < out_q.size()) ? DATA_W'(out_q[x - DEPTH]) : '0;
      if (x >= 2*DEPTH && x < 3*DEPTH)
         return (x - 2*DEPTH < in_q.size()) ? DATA_W'(in_q[x - 2*DEPTH]) : '0;
      return '0;
   endfunction

   task automatic check(string tag, logic [DATA_W-1:0] got, logic [DATA_W-1:0] expv);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, got, expv);
      end
   endtask

   task automatic model_update(bit [3:0] s, int a, bit c);
      bit fl [4];
      bit chg;
      bit r_eff, w_eff;
      for (int i = 0; i < 4; i++) fl[i] = prev[i] && !s[i];
      chg = (a != addr_prev);
      if (c) begin
         for (int i = 0; i < 4; i++) cnt[i] = 0;
         out_q.delete();
         in_q.delete();
         rd_open = 1'b0;
         wr_open = 1'b0;
      end else begin
         for (int i = 0; i < 4; i++)
            if (fl[i] && cnt[i] < CMAX) cnt[i]++;
         r_eff = rd_open && !chg;
         if (fl[1] && !r_eff) begin
            out_q.push_back(4 | a);
            if (out_q.size() > DEPTH) void'(out_q.pop_front());
         end
         rd_open = r_eff || fl[1];
         w_eff = wr_open && !chg;
         if (fl[2] && !w_eff) begin
            in_q.push_back(4 | a);
            if (in_q.size() > DEPTH) void'(in_q.pop_front());
         end
         wr_open = (w_eff || fl[2]) && !fl[3];
      end
      for (int i = 0; i < 4; i++) prev[i] = s[i];
      addr_prev = a;
   endtask

   // one cycle: compare last result, drive new inputs, advance the model
   task automatic step(bit oe, bit rd, bit wr, bit pk, int a, bit c, int ra);
      @(negedge clk);
      if (cmp_en) check(reg_tag(int'(reg_addr)), reg_data, exp_data);
      oe_n = oe; rd_n = rd; wr_n = wr; pkt_n = pk;
      fifo_addr = ADDR_W'(a);
      clr = c;
      reg_addr = REG_AW'(ra);
      next_addr = ADDR_W'($urandom);
      fifo_words = WORDS_W'($urandom);
      cur_a = a;
      exp_data = model_read(ra);
      model_update({pk, wr, rd, oe}, a, c);
      cmp_en = 1'b1;
   endtask

   function automatic int next_ra();
      ra_seq = (ra_seq + 1) % 112;
      return ra_seq;
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1, 1, 1, 1, cur_a, 0, next_ra());
   endtask

   // directed read with a hand-computed expected value
   task automatic peek(string tag, int ra, int expv);
      step(1, 1, 1, 1, cur_a, 0, ra);
      @(posedge clk);
      #1;
      check(tag, reg_data, DATA_W'(expv));
   endtask

   task automatic pulse(int lane, int a, int low_cycles);
      for (int i = 0; i < low_cycles; i++)
         step(lane != 0, lane != 1, lane != 2, lane != 3, a, 0, next_ra());
      step(1, 1, 1, 1, a, 0, next_ra());
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         cnt[i] = 0;
         prev[i] = 1'b1;
      end
      rd_open = 1'b0; wr_open = 1'b0;
      addr_prev = 0; cur_a = 0; ra_seq = 0; cmp_en = 1'b0;
      exp_data = '0;
      phase = "R9 reset";
      repeat (3) @(negedge clk);
      check("R9", reg_data, '0);
      @(negedge clk);
      rst_n = 1'b1;

      peek("R9", 0, 0);
      peek("R9", 3, 0);
      peek("R9", DEPTH, 0);
      peek("R9", 2*DEPTH, 0);

      phase = "R1 long hold";
      pulse(1, 2, 5);
      peek("R1", 1, 1);
      peek("R4", DEPTH, 6);
      peek("R6", DEPTH + 1, 0);
      phase = "R4 same buffer";
      pulse(1, 2, 1);
      peek("R1", 1, 2);
      peek("R4", DEPTH + 1, 0);
      pulse(1, 3, 2);
      peek("R4", DEPTH + 1, 7);

      phase = "R5 packet end";
      pulse(2, 0, 1);
      pulse(2, 0, 3);
      pulse(3, 0, 1);
      pulse(2, 0, 1);
      peek("R5", 2*DEPTH, 4);
      peek("R5", 2*DEPTH + 1, 4);
      peek("R5", 2*DEPTH + 2, 0);
      peek("R1", 2, 3);
      peek("R1", 3, 1);

      phase = "R3 clear";
      step(1, 0, 0, 1, cur_a, 1, next_ra());
      step(1, 1, 1, 1, cur_a, 0, next_ra());
      peek("R3", 1, 0);
      peek("R3", 2, 0);
      peek("R3", DEPTH, 0);
      peek("R3", 2*DEPTH, 0);

      phase = "R6 wrap";
      for (int k = 0; k < 40; k++) pulse(1, 2 + (k % 2), 1);
      peek("R6", DEPTH, 6);
      peek("R6", DEPTH + 1, 7);
      peek("R6", 2*DEPTH - 1, 7);
      peek("R1", 1, 40);

      phase = "R2 saturation";
      step(1, 1, 1, 1, cur_a, 1, next_ra());
      for (int k = 0; k < CMAX + 45; k++) pulse(0, cur_a, 1);
      peek("R2", 0, CMAX);
      peek("R2", 1, 0);

      phase = "R7 R8 random";
      for (int k = 0; k < 4000; k++) begin
         bit oe, rd, wr, pk, c;
         int a;
         oe = ($urandom_range(3) == 0) ? ~oe_n : oe_n;
         rd = ($urandom_range(3) == 0) ? ~rd_n : rd_n;
         wr = ($urandom_range(3) == 0) ? ~wr_n : wr_n;
         pk = ($urandom_range(5) == 0) ? ~pkt_n : pkt_n;
         a  = ($urandom_range(7) == 0) ? int'($urandom_range(3)) : cur_a;
         c  = ($urandom_range(299) == 0);
         step(oe, rd, wr, pk, a, c, next_ra());
      end
      idle(2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule